// File: doc/BRIEF.md
# Ethernet MAC Interrupt Mask Controller

This block gathers the seven event pulses produced by a simple Ethernet MAC datapath and turns them into one level-sensitive interrupt line for the CPU. The seven events are a received packet, a transmit error, an empty transmit FIFO, a FIFO overrun, a receive error, a completed management transaction and a PHY interrupt. Each event has its own sticky status bit. A status bit can only be set while its enable bit in the mask register is 1. Software clears status bits by writing ones to an acknowledge register.

Software reaches the block through a plain register port: a byte address, a write strobe, write data, and read data decoded from the address with no added latency. The port has three registers. Offset 0x0 is the read-only status. Offset 0x4 is the read/write mask. Offset 0x8 is the write-only acknowledge. When software acknowledges the transmit error, the block also sends a one-cycle pulse to the transmit FIFO. This pulse moves the FIFO write pointer back to its first entry, so a wrongly loaded frame can be written again.

Top module: `emac_irq_ctrl`

## Requirements
- R1: After reset, the mask register reads 0x0000007F. The status register reads 0. `irq_o` is 0 and `tx_ptr_rst_o` is 0.
- R2: The mask register bits map to the events as follows: bit 0 packet received, bit 1 transmit error, bit 2 transmit FIFO empty, bit 3 FIFO overrun, bit 4 receive error, bit 5 management transaction complete, bit 6 PHY interrupt. A write at offset 0x4 stores `bus_wdata[6:0]`. Bits 31:7 always read 0, and writes to them are ignored.
- R3: An event on `ev_i[n]` sets status bit n on the next clock edge if mask bit n is 1. Status bit n then stays set until it is acknowledged. The status bits use the same bit positions as the mask bits.
- R4: An event on `ev_i[n]` while mask bit n is 0 leaves status bit n at 0. Status bit n is never set without a qualified event.
- R5: A write at offset 0x8 clears each status bit whose `bus_wdata` bit is 1. Status bits whose `bus_wdata` bit is 0 are unchanged.
- R6: If a qualified event and an acknowledge hit the same status bit in the same cycle, the bit is 1 after that edge.
- R7: Clearing a mask bit while its status bit is set leaves the status bit set.
- R8: `irq_o` equals the OR of the seven status bits. It changes in the same cycle the status register changes.
- R9: `tx_ptr_rst_o` is high for exactly the one cycle that follows a write at offset 0x8 with `bus_wdata[1]` = 1. It does not depend on the state of the status bit. It is low at all other times.
- R10: Offset 0x8 and unmapped offsets read 0. Writes at offset 0x0 leave the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Byte address of the register being accessed |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| ev_i | input | NUM_SRC (7) | Event pulses from the datapath, one per source |
| irq_o | output | 1 | Interrupt request to the CPU |
| tx_ptr_rst_o | output | 1 | One-cycle pulse that resets the transmit FIFO write pointer |

## Verification
The assertions assume that the address, write strobe, write data and event inputs are stable around each rising clock edge. They also assume that no write is issued while reset is asserted, because the pointer-reset check compares against the previous cycle's acknowledge. The bench drives every input on the falling edge and holds the bus idle during reset. Its random phase uses only the defined offsets plus one unmapped offset, so every cycle is covered by the behavioural model.

// File: rtl/emac_irq_pkg.sv
package emac_irq_pkg;
   localparam int unsigned OFS_STATUS = 0;
   localparam int unsigned OFS_MASK   = 4;
   localparam int unsigned OFS_ACK    = 8;
   localparam int unsigned TXERR_IDX  = 1;

   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_STATUS,
      SEL_MASK,
      SEL_ACK
   } reg_sel_e;
endpackage

// File: rtl/emac_irq_regif.sv
module emac_irq_regif
   import emac_irq_pkg::*;
#(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned NUM_SRC = 7
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic               wr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [NUM_SRC-1:0] status,
   input  logic [NUM_SRC-1:0] mask,
   output logic               mask_we,
   output logic [NUM_SRC-1:0] mask_wdata,
   output logic [NUM_SRC-1:0] ack_vec,
   output logic [DATA_W-1:0]  rdata
);
   reg_sel_e sel;

   always_comb begin
      if (addr == ADDR_W'(OFS_STATUS))    sel = SEL_STATUS;
      else if (addr == ADDR_W'(OFS_MASK)) sel = SEL_MASK;
      else if (addr == ADDR_W'(OFS_ACK))  sel = SEL_ACK;
      else                                sel = SEL_NONE;
   end

   assign mask_we    = wr && (sel == SEL_MASK);
   assign mask_wdata = wdata[NUM_SRC-1:0];
   assign ack_vec    = (wr && (sel == SEL_ACK)) ? wdata[NUM_SRC-1:0] : '0;

   always_comb begin
      rdata = '0;
      case (sel)
         SEL_STATUS: rdata[NUM_SRC-1:0] = status;
         SEL_MASK:   rdata[NUM_SRC-1:0] = mask;
         default:    rdata = '0;
      endcase
   end

   generate
      if (NUM_SRC < DATA_W) begin : g_hi
         logic unused_hi_bits;
         assign unused_hi_bits = ^wdata[DATA_W-1:NUM_SRC];
      end
   endgenerate
endmodule

// File: rtl/emac_irq_mask_reg.sv
module emac_irq_mask_reg #(
   parameter int unsigned NUM_SRC = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [NUM_SRC-1:0] wdata,
   output logic [NUM_SRC-1:0] mask
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mask <= '1;
      else if (we) mask <= wdata;
   end
endmodule

// File: rtl/emac_irq_status.sv
module emac_irq_status #(
   parameter int unsigned NUM_SRC = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] ev,
   input  logic [NUM_SRC-1:0] mask,
   input  logic [NUM_SRC-1:0] ack,
   output logic [NUM_SRC-1:0] status
);
   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
         logic bit_q;
         // a qualified event outranks a same-cycle acknowledge
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                bit_q <= 1'b0;
            else if (ev[i] && mask[i]) bit_q <= 1'b1;
            else if (ack[i])           bit_q <= 1'b0;
         end
         assign status[i] = bit_q;
      end
   endgenerate
endmodule

// File: rtl/emac_irq_out.sv
module emac_irq_out
   import emac_irq_pkg::*;
#(
   parameter int unsigned NUM_SRC = 7,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] status,
   input  logic [NUM_SRC-1:0] ack_vec,
   output logic               irq,
   output logic               tx_ptr_rst
);
   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= |status;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = |status;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tx_ptr_rst <= 1'b0;
      else        tx_ptr_rst <= ack_vec[TXERR_IDX];
   end
endmodule

// File: rtl/emac_irq_ctrl.sv
module emac_irq_ctrl
   import emac_irq_pkg::*;
#(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned NUM_SRC = 7,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [NUM_SRC-1:0] ev_i,
   output logic               irq_o,
   output logic               tx_ptr_rst_o
);
   generate
      if (NUM_SRC > DATA_W) begin : g_bad_width
         $error("NUM_SRC must not exceed DATA_W");
      end
      if (NUM_SRC <= TXERR_IDX) begin : g_bad_src
         $error("NUM_SRC must include the transmit error source");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("ADDR_W must reach offset 0x8");
      end
   endgenerate

   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] status_q;
   logic [NUM_SRC-1:0] ack_vec;
   logic [NUM_SRC-1:0] mask_wdata;
   logic               mask_we;

   emac_irq_regif #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .NUM_SRC(NUM_SRC)
   ) u_regif (
      .addr      (bus_addr),
      .wr        (bus_wr),
      .wdata     (bus_wdata),
      .status    (status_q),
      .mask      (mask_q),
      .mask_we   (mask_we),
      .mask_wdata(mask_wdata),
      .ack_vec   (ack_vec),
      .rdata     (bus_rdata)
   );

   emac_irq_mask_reg #(
      .NUM_SRC(NUM_SRC)
   ) u_mask (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (mask_we),
      .wdata(mask_wdata),
      .mask (mask_q)
   );

   emac_irq_status #(
      .NUM_SRC(NUM_SRC)
   ) u_status (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    (ev_i),
      .mask  (mask_q),
      .ack   (ack_vec),
      .status(status_q)
   );

   emac_irq_out #(
      .NUM_SRC(NUM_SRC),
      .IRQ_REG(IRQ_REG)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .status    (status_q),
      .ack_vec   (ack_vec),
      .irq       (irq_o),
      .tx_ptr_rst(tx_ptr_rst_o)
   );
endmodule

// File: rtl/emac_irq_ctrl_chk.sv
module emac_irq_ctrl_chk
   import emac_irq_pkg::*;
#(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned NUM_SRC = 7,
   parameter bit          IRQ_REG = 1'b0
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               bus_wr,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic [NUM_SRC-1:0] ev_i,
   input logic [NUM_SRC-1:0] status_q,
   input logic [NUM_SRC-1:0] mask_q,
   input logic               irq_o,
   input logic               tx_ptr_rst_o
);
   logic [NUM_SRC-1:0] ack_seen;
   logic [NUM_SRC-1:0] qual_ev;
   logic               mask_wr;

   assign ack_seen = (bus_wr && bus_addr == ADDR_W'(OFS_ACK)) ? bus_wdata[NUM_SRC-1:0] : '0;
   assign qual_ev  = ev_i & mask_q;
   assign mask_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_MASK));

   generate
      if (NUM_SRC < DATA_W) begin : g_hi
         logic unused_chk_hi;
         assign unused_chk_hi = ^bus_wdata[DATA_W-1:NUM_SRC];
      end
   endgenerate

   p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_wr |=> $stable(mask_q));

   p_event_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (qual_ev != '0) |=> ((status_q & $past(qual_ev)) == $past(qual_ev)));

   p_no_spurious_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_q & ~$past(status_q) & ~$past(qual_ev)) == '0));

   p_clear_by_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(status_q) & ~status_q & ~$past(ack_seen)) == '0));

   generate
      if (IRQ_REG) begin : g_irq_reg
         p_irq_or_r8: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq_o == $past(|status_q)));
      end else begin : g_irq_comb
         p_irq_or_r8: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o == (|status_q));
      end
   endgenerate

   p_ptr_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (tx_ptr_rst_o == $past(ack_seen[TXERR_IDX])));
endmodule

bind emac_irq_ctrl emac_irq_ctrl_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .NUM_SRC(NUM_SRC),
   .IRQ_REG(IRQ_REG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_addr    (bus_addr),
   .bus_wr      (bus_wr),
   .bus_wdata   (bus_wdata),
   .ev_i        (ev_i),
   .status_q    (status_q),
   .mask_q      (mask_q),
   .irq_o       (irq_o),
   .tx_ptr_rst_o(tx_ptr_rst_o)
);

// File: tb/emac_irq_ctrl_bench.sv
module emac_irq_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [6:0]  ev_i = '0;
   logic        irq_o;
   logic        tx_ptr_rst_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // behavioural reference state
   int m_mask = 32'h7F;
   int m_stat = 0;
   int m_ptr  = 0;

   always #2 clk = ~clk;

   emac_irq_ctrl u_emac_irq_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr    (bus_addr),
      .bus_wr      (bus_wr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .ev_i        (ev_i),
      .irq_o       (irq_o),
      .tx_ptr_rst_o(tx_ptr_rst_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [3:0] a);
      if (a == 4'h0) return 32'(m_stat);
      if (a == 4'h4) return 32'(m_mask);
      return 32'h0;
   endfunction

   task automatic cyc(input logic [3:0] a, input logic w, input logic [31:0] d,
                      input logic [6:0] e, input string tag);
      int ack;
      @(negedge clk);
      bus_addr = a; bus_wr = w; bus_wdata = d; ev_i = e;
      #1;
      chk(tag, bus_rdata, exp_read(a));
      @(posedge clk);
      ack = (w && a == 4'h8) ? int'(d[6:0]) : 0;
      m_stat = (m_stat & ~ack) | (int'(e) & m_mask);
      if (w && a == 4'h4) m_mask = int'(d[6:0]);
      m_ptr = (ack >> 1) & 1;
      #1;
      chk("R8 irq", {31'b0, irq_o}, {31'b0, (m_stat != 0)});
      chk("R9 ptr", {31'b0, tx_ptr_rst_o}, 32'(m_ptr));
   endtask

   task automatic rd(input logic [3:0] a, input string tag);
      cyc(a, 1'b0, 32'h0, 7'h0, tag);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 irq in reset", {31'b0, irq_o}, 32'h0);
      chk("R1 ptr in reset", {31'b0, tx_ptr_rst_o}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      rd(4'h4, "R1 mask reset");
      rd(4'h0, "R1 status reset");

      // R2 mask write, upper bits dropped
      cyc(4'h4, 1'b1, 32'hFFFF_FFAA, 7'h0, "R2 write");
      rd(4'h4, "R2 mask readback");
      cyc(4'h4, 1'b1, 32'h0000_007F, 7'h0, "R2 restore");
      rd(4'h4, "R2 mask full");

      // R3 sticky set
      cyc(4'h0, 1'b0, 0, 7'h01, "R3 event");
      rd(4'h0, "R3 sticky bit0");
      cyc(4'h0, 1'b0, 0, 7'h40, "R3 event bit6");
      rd(4'h0, "R3 sticky bits");

      // R5 partial and full acknowledge
      cyc(4'h8, 1'b1, 32'h0000_0001, 7'h0, "R5 ack bit0");
      rd(4'h0, "R5 bit6 kept");
      cyc(4'h8, 1'b1, 32'h0000_007F, 7'h0, "R5 ack all");
      rd(4'h0, "R5 cleared");

      // R4 masked events never set status
      cyc(4'h4, 1'b1, 32'h0, 7'h0, "R4 mask off");
      cyc(4'h0, 1'b0, 0, 7'h7F, "R4 event masked");
      rd(4'h0, "R4 status zero");
      cyc(4'h4, 1'b1, 32'h55, 7'h0, "R4 partial mask");
      cyc(4'h0, 1'b0, 0, 7'h7F, "R4 event partial");
      rd(4'h0, "R4 status 0x55");
      cyc(4'h8, 1'b1, 32'h7F, 7'h0, "R4 cleanup");
      cyc(4'h4, 1'b1, 32'h7F, 7'h0, "R4 unmask");

      // R6 event beats acknowledge
      cyc(4'h0, 1'b0, 0, 7'h08, "R6 set");
      cyc(4'h8, 1'b1, 32'h08, 7'h08, "R6 collide");
      rd(4'h0, "R6 still set");

      // R7 masking leaves existing status
      cyc(4'h0, 1'b0, 0, 7'h7F, "R7 set all");
      cyc(4'h4, 1'b1, 32'h0, 7'h0, "R7 mask off");
      rd(4'h0, "R7 status kept");

      // R10 status read-only, ack and unmapped read zero
      cyc(4'h0, 1'b1, 32'h0, 7'h0, "R10 status write");
      rd(4'h0, "R10 status unchanged");
      cyc(4'h8, 1'b0, 0, 7'h0, "R10 ack reads zero");
      cyc(4'hC, 1'b0, 0, 7'h0, "R10 unmapped reads zero");

      // R9 pointer reset pulse
      cyc(4'h8, 1'b1, 32'h02, 7'h0, "R9 ack txerr");
      rd(4'h0, "R9 after pulse");
      cyc(4'h8, 1'b1, 32'h01, 7'h0, "R9 other ack");
      cyc(4'h8, 1'b1, 32'h02, 7'h0, "R9 ack txerr when clear");
      cyc(4'h8, 1'b1, 32'h7F, 7'h0, "R9 clear all");
      cyc(4'h4, 1'b1, 32'h7F, 7'h0, "R9 unmask");

      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [3:0] a;
         logic [31:0] d;
         logic [6:0] e;
         logic w;
         a = 4'((($urandom % 4)) * 4);
         w = ($urandom % 3) == 0;
         d = $urandom;
         e = 7'($urandom) & 7'($urandom);
         cyc(a, w, d, e, "R3 random");
      end

      done = 1'b1;
      finish_run();
   end
endmodule